// File: doc/BRIEF.md
# Node Transaction Busy-Retry Controller

This controller sits in each node of a distributed coherent memory system and makes the node's own outstanding transaction look atomic to every other node. When local logic asks for a transaction, the controller issues a request carrying a fresh tag and holds the node busy until a response with that tag comes back. While the node is busy, any request arriving from another node is refused with a retry answer, so a third party cannot change this node's state halfway through the exchange.

If this node's own request is itself refused with a busy response, the controller waits a fixed backoff and sends the same request again. It gives up after a bounded number of attempts. A timeout covering the whole transaction forces it to fail if it stalls. A chain of nodes that are each waiting on the next therefore always breaks in the end, and each node starts accepting incoming requests again as soon as it leaves the busy state. Message transport and cache data storage are outside this block.

Top module: `txn_busy_ctrl`

## Requirements
- R1: When `start_i` is sampled high while the controller is idle, `req_valid_o` is high for exactly one cycle in the next cycle. `req_tag_o` then carries the previous tag plus one, modulo 2^TAG_W, and `busy_o` goes high in that same cycle.
- R2: An `in_req_i` sampled while `busy_o` is high is answered in the next cycle with `in_retry_o` high and `in_ack_o` low. An `in_req_i` sampled while `busy_o` is low is answered with `in_ack_o` high and `in_retry_o` low. Without a request, both outputs stay low.
- R3: While the controller waits for a response, a response with `rsp_tag_i` equal to the outstanding tag and `rsp_busy_i` low ends the transaction. In the next cycle `done_o` is high for one cycle and `busy_o` is low.
- R4: A response whose tag differs from the outstanding tag is dropped, and so is a response that arrives while no request is awaiting an answer (idle, backoff or failed). Neither changes any output.
- R5: A matching response with `rsp_busy_i` high, on an attempt below MAX_TRIES, puts the controller into backoff for BACKOFF_CYC cycles. After that, `req_valid_o` pulses again with the same tag, and `busy_o` stays high throughout.
- R6: A matching busy response to attempt number MAX_TRIES ends the transaction. In the next cycle `fail_o` and `exhaust_o` are both high for one cycle and `busy_o` is low.
- R7: A transaction that has not completed after TIMEOUT busy cycles, counted from the cycle after `start_i` is accepted and including backoff, fails. In the next cycle `fail_o` is high for one cycle, `exhaust_o` is low and `busy_o` is low. The count restarts with every new transaction.
- R8: A matching response sampled in the same cycle in which the timeout expires takes precedence. The transaction completes (or backs off or exhausts) instead of timing out.
- R9: `start_i` is ignored while `busy_o` or `fail_o` is high. In the cycle `fail_o` is high, the controller is not busy, and incoming requests are acknowledged.
- R10: While `rst` is high, and in the first cycle after it, every output is low and the tag register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Open a new transaction (only taken when idle) |
| rsp_valid_i | input | 1 | A response to this node's request is present |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| rsp_busy_i | input | 1 | The response is a busy/retry refusal |
| in_req_i | input | 1 | A request from another node is present |
| req_valid_o | output | 1 | One-cycle pulse: issue (or reissue) the outgoing request |
| req_tag_o | output | TAG_W | Tag of the outstanding transaction |
| busy_o | output | 1 | A transaction is open (waiting or backing off) |
| done_o | output | 1 | One-cycle pulse: transaction completed |
| fail_o | output | 1 | One-cycle pulse: transaction failed |
| exhaust_o | output | 1 | With `fail_o`: failure caused by running out of attempts |
| in_ack_o | output | 1 | Incoming request accepted |
| in_retry_o | output | 1 | Incoming request refused, sender must retry |

## Verification
Two functions can land on the same edge. One is the arrival of the matching response, and the other is the expiry of the transaction timer. The bench provokes this collision directly by starting a transaction and holding back the good response until exactly the TIMEOUT-th busy cycle. It then expects `done_o` and not `fail_o`. A second collision comes from an incoming request sampled on the same edge that closes the transaction. That request must still be refused, because busy is judged by the state held before the edge, and the following cycle's request must be acknowledged. Random phases mix starts, stale and matching tags, busy refusals and foreign requests, so both collisions also occur unplanned, and every cycle is judged against the bench's own reading of the requirements.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_FAIL    = 2'd3
  } txn_state_e;

endpackage

// File: rtl/txn_timeout.sv
// Counts busy cycles of the open transaction; flags the last allowed one.
module txn_timeout #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/txn_backoff.sv
// Down-counter holding the controller in backoff for CYC cycles.
module txn_backoff #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic elapsed
);
  localparam int W = $clog2(CYC + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= W'(CYC - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign elapsed = run && (cnt == '0);
endmodule

// File: rtl/txn_inbound.sv
// Answers requests from other nodes: accept when free, refuse when busy.
module txn_inbound (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic busy,
  output logic ack,
  output logic retry
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      retry <= 1'b0;
    end else begin
      ack   <= req && !busy;
      retry <= req && busy;
    end
  end
endmodule

// File: rtl/txn_busy_ctrl.sv
module txn_busy_ctrl #(
  parameter int TAG_W       = 4,
  parameter int TIMEOUT     = 1024,
  parameter int BACKOFF_CYC = 4,
  parameter int MAX_TRIES   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rsp_valid_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  input  logic             rsp_busy_i,
  input  logic             in_req_i,
  output logic             req_valid_o,
  output logic [TAG_W-1:0] req_tag_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             exhaust_o,
  output logic             in_ack_o,
  output logic             in_retry_o
);
  import txn_pkg::*;

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES);

  txn_state_e       state, state_n;
  logic [TAG_W-1:0] tag_q;
  logic [TRY_W-1:0] tries_q;
  logic             in_busy;
  logic             tmo_hit, bo_done, bo_load;
  logic             rsp_hit;
  logic             take_start;

  assign in_busy    = (state == ST_WAIT) || (state == ST_BACKOFF);
  assign take_start = (state == ST_IDLE) && start_i;
  assign rsp_hit    = (state == ST_WAIT) && rsp_valid_i && (rsp_tag_i == tag_q);
  assign bo_load    = rsp_hit && rsp_busy_i && (tries_q != TRY_LAST);

  txn_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clear   (take_start),
    .run     (in_busy),
    .expired (tmo_hit)
  );

  txn_backoff #(.CYC(BACKOFF_CYC)) u_bo (
    .clk     (clk),
    .rst     (rst),
    .load    (bo_load),
    .run     (state == ST_BACKOFF),
    .elapsed (bo_done)
  );

  txn_inbound u_in (
    .clk   (clk),
    .rst   (rst),
    .req   (in_req_i),
    .busy  (in_busy),
    .ack   (in_ack_o),
    .retry (in_retry_o)
  );

  // Next-state: in WAIT a matching response outranks the timer; in
  // BACKOFF the timer outranks the end of the backoff window.
  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:    if (start_i) state_n = ST_WAIT;
      ST_WAIT: begin
        if (rsp_hit) begin
          if (!rsp_busy_i)               state_n = ST_IDLE;
          else if (tries_q == TRY_LAST)  state_n = ST_FAIL;
          else                           state_n = ST_BACKOFF;
        end else if (tmo_hit) begin
          state_n = ST_FAIL;
        end
      end
      ST_BACKOFF: begin
        if (tmo_hit)      state_n = ST_FAIL;
        else if (bo_done) state_n = ST_WAIT;
      end
      ST_FAIL:    state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tag_q       <= '0;
      tries_q     <= '0;
      req_valid_o <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      exhaust_o   <= 1'b0;
    end else begin
      state       <= state_n;
      req_valid_o <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      exhaust_o   <= 1'b0;
      if (take_start) begin
        tag_q       <= tag_q + 1'b1;
        tries_q     <= TRY_W'(1);
        req_valid_o <= 1'b1;
      end
      if (state == ST_BACKOFF && state_n == ST_WAIT) begin
        tries_q     <= tries_q + 1'b1;
        req_valid_o <= 1'b1;
      end
      if (state == ST_WAIT && rsp_hit && !rsp_busy_i) begin
        done_o <= 1'b1;
      end
      if (state != ST_FAIL && state_n == ST_FAIL) begin
        fail_o    <= 1'b1;
        exhaust_o <= rsp_hit;
      end
    end
  end

  assign req_tag_o = tag_q;
  assign busy_o    = in_busy;

endmodule

// File: rtl/txn_busy_ctrl_chk.sv
module txn_busy_ctrl_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             in_req_i,
  input logic             req_valid_o,
  input logic [TAG_W-1:0] req_tag_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             exhaust_o,
  input logic             in_ack_o,
  input logic             in_retry_o
);
  a_r1_start_issues: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o && !fail_o |=> req_valid_o && busy_o);

  a_r1_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> busy_o);

  a_r2_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    in_req_i && busy_o |=> in_retry_o && !in_ack_o);

  a_r2_accept_free: assert property (@(posedge clk) disable iff (rst)
    in_req_i && !busy_o |=> in_ack_o && !in_retry_o);

  a_r2_answer_needs_req: assert property (@(posedge clk) disable iff (rst)
    !in_req_i |=> !in_ack_o && !in_retry_o);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !fail_o);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r5_tag_held: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(req_tag_o));

  a_r6_exhaust_with_fail: assert property (@(posedge clk) disable iff (rst)
    exhaust_o |-> fail_o);

  a_r7_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> !busy_o ##1 !fail_o);

  a_r9_no_start_in_fail: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !req_valid_o);
endmodule

bind txn_busy_ctrl txn_busy_ctrl_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/txn_busy_ctrl_tb.sv
`timescale 1ns/1ps
module txn_busy_ctrl_tb;
  localparam int TAG_W = 4;
  localparam int TO    = 40;
  localparam int BO    = 3;
  localparam int MAXT  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, rsp_valid_i = 0, rsp_busy_i = 0, in_req_i = 0;
  logic [TAG_W-1:0] rsp_tag_i = '0;
  logic req_valid_o, busy_o, done_o, fail_o, exhaust_o, in_ack_o, in_retry_o;
  logic [TAG_W-1:0] req_tag_o;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  txn_busy_ctrl #(.TAG_W(TAG_W), .TIMEOUT(TO), .BACKOFF_CYC(BO), .MAX_TRIES(MAXT)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .rsp_valid_i(rsp_valid_i),
    .rsp_tag_i(rsp_tag_i), .rsp_busy_i(rsp_busy_i), .in_req_i(in_req_i),
    .req_valid_o(req_valid_o), .req_tag_o(req_tag_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .exhaust_o(exhaust_o),
    .in_ack_o(in_ack_o), .in_retry_o(in_retry_o));

  // Bench-side model of the requirements: 0 idle, 1 waiting, 2 backoff, 3 failed
  int m_st = 0, m_tcnt = 0, m_bo = 0, m_try = 0;
  logic [TAG_W-1:0] m_tag = '0;
  logic e_req, e_busy, e_done, e_fail, e_exh, e_ack, e_retry;

  task automatic chk(input logic ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic logic is_busy(input int s);
    return (s == 1) || (s == 2);
  endfunction

  task automatic model_step();
    int  ns;
    logic b, hit;
    b  = is_busy(m_st);
    ns = m_st;
    e_ack = in_req_i && !b;             // R2
    e_retry = in_req_i && b;
    e_req = 0; e_done = 0; e_fail = 0; e_exh = 0;
    hit = rsp_valid_i && (rsp_tag_i == m_tag) && (m_st == 1);
    case (m_st)
      0: if (start_i) begin ns = 1; m_tag = m_tag + 1'b1; m_try = 1; e_req = 1; end
      1: begin
        if (hit) begin
          if (!rsp_busy_i) begin ns = 0; e_done = 1; end
          else if (m_try == MAXT) begin ns = 3; e_fail = 1; e_exh = 1; end
          else begin ns = 2; m_bo = BO - 1; end
        end else if (m_tcnt == TO - 1) begin ns = 3; e_fail = 1; end
      end
      2: begin
        if (m_tcnt == TO - 1) begin ns = 3; e_fail = 1; end
        else if (m_bo == 0) begin ns = 1; m_try++; e_req = 1; end
        else m_bo--;
      end
      default: ns = 0;
    endcase
    if (m_st == 0 && start_i) m_tcnt = 0;
    else if (b && m_tcnt != TO - 1) m_tcnt++;
    m_st = ns;
    e_busy = is_busy(ns);
  endtask

  task automatic compare();
    chk(req_valid_o === e_req, "R1/R5", "req_valid_o", req_valid_o, e_req);
    if (e_req) chk(req_tag_o === m_tag, "R1/R5", "req_tag_o", req_tag_o, m_tag);
    chk(busy_o === e_busy, "R1/R3", "busy_o", busy_o, e_busy);
    chk(done_o === e_done, "R3/R4", "done_o", done_o, e_done);
    chk(fail_o === e_fail, "R7", "fail_o", fail_o, e_fail);
    chk(exhaust_o === e_exh, "R6", "exhaust_o", exhaust_o, e_exh);
    chk(in_ack_o === e_ack, "R2", "in_ack_o", in_ack_o, e_ack);
    chk(in_retry_o === e_retry, "R2", "in_retry_o", in_retry_o, e_retry);
  endtask

  // One clock: drive at negedge, model, edge, sample at next negedge
  task automatic cyc(input logic st, input logic rv, input logic [TAG_W-1:0] rt,
                     input logic rb, input logic ir);
    start_i = st; rsp_valid_i = rv; rsp_tag_i = rt; rsp_busy_i = rb; in_req_i = ir;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [TAG_W-1:0] old_tag;
    seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk);
    @(negedge clk);
    // R10: reset values
    chk({req_valid_o, busy_o, done_o, fail_o, exhaust_o, in_ack_o, in_retry_o} === 7'b0,
        "R10", "outputs in reset", int'(busy_o), 0);
    chk(req_tag_o === '0, "R10", "tag in reset", req_tag_o, 0);
    rst = 0;
    idle(1);

    // R1/R3: plain transaction with foreign requests on both sides
    cyc(1, 0, '0, 0, 1);                 // request while idle -> ack (R2)
    cyc(0, 0, '0, 0, 1);                 // now busy -> retry
    idle(3);
    cyc(1, 1, m_tag, 0, 0);              // start ignored while busy (R9)
    cyc(0, 0, '0, 0, 1);                 // free again -> ack

    // R4: stale tag dropped, then matching
    cyc(1, 0, '0, 0, 0);
    cyc(0, 1, m_tag - 1'b1, 0, 0);
    cyc(0, 1, m_tag + 1'b1, 0, 0);
    chk(busy_o === 1'b1, "R4", "busy after stale tag", busy_o, 1);
    cyc(0, 1, m_tag, 0, 1);              // closes txn; request same edge -> retry
    cyc(0, 1, m_tag, 0, 1);              // response while idle ignored (R4)

    // R5: one refusal, backoff, reissue, success
    cyc(1, 0, '0, 0, 0);
    cyc(0, 1, m_tag, 1, 0);
    cyc(0, 1, m_tag, 0, 0);              // in backoff: ignored (R4)
    idle(BO - 1);
    cyc(0, 1, m_tag, 0, 0);

    // R6: exhaust all attempts
    cyc(1, 0, '0, 0, 0);
    for (int k = 0; k < MAXT; k++) begin
      cyc(0, 1, m_tag, 1, 0);
      if (k != MAXT - 1) idle(BO);
    end
    chk(fail_o === 1'b1 && exhaust_o === 1'b1, "R6", "exhaust fail", fail_o, 1);
    cyc(1, 0, '0, 0, 1);                 // start in fail cycle ignored, ack (R9)
    chk(req_valid_o === 1'b0, "R9", "start ignored in fail", req_valid_o, 0);

    // R7: timeout, then stale late response dropped
    cyc(1, 0, '0, 0, 0);
    old_tag = m_tag;
    idle(TO - 1);
    cyc(0, 0, '0, 0, 1);
    chk(fail_o === 1'b1 && exhaust_o === 1'b0, "R7", "timeout fail", fail_o, 1);
    idle(2);
    cyc(1, 0, '0, 0, 0);
    cyc(0, 1, old_tag, 0, 0);            // stale after timeout (R4)
    idle(TO - 3);                        // timer restarted by new start (R7)
    cyc(0, 1, m_tag, 0, 0);
    chk(done_o === 1'b1, "R7", "timer restarted per txn", done_o, 1);

    // R8: response lands on the expiry cycle
    cyc(1, 0, '0, 0, 0);
    idle(TO - 1);
    cyc(0, 1, m_tag, 0, 0);
    chk(done_o === 1'b1 && fail_o === 1'b0, "R8", "response beats timeout", done_o, 1);

    // Random mix
    for (int n = 0; n < 6000; n++) begin
      logic st, rv, rb, ir;
      logic [TAG_W-1:0] rt;
      st = ($urandom % 4) == 0;
      rv = ($urandom % 5) == 0;
      rb = ($urandom % 2) == 0;
      ir = ($urandom % 3) == 0;
      rt = (($urandom % 5) == 0) ? TAG_W'($urandom) : m_tag;
      cyc(st, rv, rt, rb, ir);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule